// File: doc/BRIEF.md
# Sub-Blocked Direct-Mapped Cache

This block is a direct-mapped, word-addressed cache whose lines are split into smaller sub-blocks. A line carries one address tag, and each sub-block inside it has a valid bit of its own. A long line can therefore be kept while the tag storage per cached word stays small. A miss moves only the sub-block that holds the requested word, so the refill is short even though the line is long.

The processor side presents one request at a time. It holds the request, write flag, address and write data steady until the cache raises ready. A read that finds its tag and sub-block valid completes in the same cycle. A read miss stalls the requester while one sub-block is fetched over the memory port. The requested word is returned in the cycle the fill response arrives. Writes always go through to memory and never allocate. A write also updates the cached copy when its word is already resident.

Top module: `subblock_cache`

## Requirements
- R1: After reset every sub-block of every line is invalid, so the first read of any address misses. memReq and cpuReady are low while no request is pending.
- R2: A read is a hit only when the stored tag of the indexed line equals the address tag and the addressed sub-block's valid bit is set. A read hit raises cpuReady and cpuHit in the cycle the request is presented, with the cached word on cpuRdata and no memory request.
- R3: A read whose tag matches but whose sub-block is invalid fetches only that sub-block. Other sub-blocks of the line that were valid stay valid.
- R4: A read whose tag differs from the stored tag writes the new tag into the line and invalidates all of its sub-blocks before the requested sub-block is filled. A sub-block that was valid under the old tag is therefore no longer a hit for the new tag.
- R5: A refill issues exactly one memory request with memWe low. memAddr is the word address of the sub-block start, meaning the address with its in-sub-block word-offset bits (the lowest log2(WORDS_PER_SUB) bits) forced to zero. The request is dropped in the cycle after memAck.
- R6: While a memory request is outstanding and memAck is low, cpuReady stays low. On a refill, cpuReady rises in the memAck cycle with cpuHit low. cpuRdata then carries the requested word taken from memRdata, where word w of the sub-block sits at bits [w*DATA_W +: DATA_W].
- R7: Every write issues one memory request with memWe high, memAddr equal to the write address and memWdata equal to the write data. cpuReady rises in the memAck cycle.
- R8: A write whose tag matches and whose sub-block is valid reports cpuHit and updates the cached word, so a later read of that address hits and returns the new data.
- R9: A write that misses (tag mismatch or invalid sub-block) changes neither tags nor valid bits. A later read of that address misses, and sub-blocks still valid under the old tag keep hitting.
- R10: A refill stores every word of the fetched sub-block, so a later read of any other word in that sub-block hits and returns memory's value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuReq | input | 1 | Request valid, held until cpuReady |
| cpuWe | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | ADDR_W | Word address |
| cpuWdata | input | DATA_W | Write data |
| cpuRdata | output | DATA_W | Read data, valid with cpuReady on a read |
| cpuReady | output | 1 | Request completes this cycle |
| cpuHit | output | 1 | The completing request hit in the cache |
| memReq | output | 1 | Memory request, held until memAck |
| memWe | output | 1 | 1 = write-through, 0 = sub-block refill |
| memAddr | output | ADDR_W | Word address (sub-block start on refill) |
| memWdata | output | DATA_W | Write-through data |
| memAck | input | 1 | Memory completes the request this cycle |
| memRdata | input | WORDS_PER_SUB*DATA_W | Whole sub-block returned with memAck on a refill |

## Verification
The bench first sweeps every word of one tag region in ascending order. There the first word of each sub-block must miss and its neighbour must hit, which separates a per-sub-block fill from a per-word or per-line fill. A repeat of the sweep must hit everywhere. Directed conflicts then read a second tag into an occupied line and come back to the first tag, which separates tag reallocation with invalidation from stale valid bits. Write hits and write misses are each followed by reads, which show whether the write updated the cache, allocated, or disturbed the tag. A long pseudo-random mix of reads and writes over a small cache is scored against an arithmetic model of tags, valid bits and memory contents.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

  // Strobes from the controller to the datapath
  typedef struct packed {
    logic allocLine;  // write new tag, clear all sub-block valid bits
    logic fillSub;    // store returned sub-block, set its valid bit
    logic writeWord;  // update one cached word on a write hit
    logic useFill;    // steer returned fill data onto the read port
  } dpCtrl_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FILL  = 2'd1,
    ST_WRITE = 2'd2
  } ctrlState_t;

endpackage

// File: rtl/sbc_datapath.sv
module sbc_datapath
  import sbc_pkg::*;
#(
  parameter int ADDR_W        = 10,
  parameter int DATA_W        = 32,
  parameter int WORDS_PER_SUB = 2,
  parameter int SUBS_PER_LINE = 4,
  parameter int LINES         = 8
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  dpCtrl_t                         ctrl,
  input  logic [ADDR_W-1:0]               cpuAddr,
  input  logic [DATA_W-1:0]               cpuWdata,
  input  logic [WORDS_PER_SUB*DATA_W-1:0] memRdata,
  output logic                            tagMatch,
  output logic                            subValid,
  output logic [DATA_W-1:0]               rdData
);

  localparam int OFF_W  = $clog2(WORDS_PER_SUB);
  localparam int SIDX_W = $clog2(SUBS_PER_LINE);
  localparam int IDX_W  = $clog2(LINES);
  localparam int LOC_W  = OFF_W + SIDX_W + IDX_W;
  localparam int TAG_W  = ADDR_W - LOC_W;
  localparam int NWORDS = LINES * SUBS_PER_LINE * WORDS_PER_SUB;

  logic [OFF_W-1:0]  wordOff;
  logic [SIDX_W-1:0] subIdx;
  logic [IDX_W-1:0]  lineIdx;
  logic [TAG_W-1:0]  addrTag;
  logic [LOC_W-1:0]  locIdx;

  assign wordOff = cpuAddr[OFF_W-1:0];
  assign subIdx  = cpuAddr[OFF_W +: SIDX_W];
  assign lineIdx = cpuAddr[OFF_W+SIDX_W +: IDX_W];
  assign addrTag = cpuAddr[ADDR_W-1:LOC_W];
  assign locIdx  = cpuAddr[LOC_W-1:0];

  logic [TAG_W-1:0]         tagArr   [LINES];
  logic [SUBS_PER_LINE-1:0] validArr [LINES];
  logic [DATA_W-1:0]        dataArr  [NWORDS];
  logic [DATA_W-1:0]        fillWord [WORDS_PER_SUB];

  genvar gw;
  generate
    for (gw = 0; gw < WORDS_PER_SUB; gw++) begin : g_fill_split
      assign fillWord[gw] = memRdata[gw*DATA_W +: DATA_W];
    end
  endgenerate

  // Tag and validity state
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < LINES; i++) begin
        tagArr[i]   <= '0;
        validArr[i] <= '0;
      end
    end else begin
      if (ctrl.allocLine) begin
        tagArr[lineIdx]   <= addrTag;
        validArr[lineIdx] <= '0;
      end
      if (ctrl.fillSub) begin
        validArr[lineIdx][subIdx] <= 1'b1;
      end
    end
  end

  // Word storage
  always_ff @(posedge clk) begin
    if (ctrl.fillSub) begin
      for (int w = 0; w < WORDS_PER_SUB; w++) begin
        dataArr[{locIdx[LOC_W-1:OFF_W], OFF_W'(w)}] <= fillWord[w];
      end
    end else if (ctrl.writeWord) begin
      dataArr[locIdx] <= cpuWdata;
    end
  end

  assign tagMatch = (tagArr[lineIdx] == addrTag);
  assign subValid = validArr[lineIdx][subIdx];
  assign rdData   = ctrl.useFill ? fillWord[wordOff] : dataArr[locIdx];

endmodule

// File: rtl/sbc_ctrl.sv
module sbc_ctrl
  import sbc_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    cpuReq,
  input  logic    cpuWe,
  input  logic    tagMatch,
  input  logic    subValid,
  input  logic    memAck,
  output dpCtrl_t ctrl,
  output logic    memReq,
  output logic    memWe,
  output logic    cpuReady,
  output logic    cpuHit
);

  ctrlState_t state, stateNext;
  logic lookupHit;

  assign lookupHit = tagMatch & subValid;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    ctrl      = '0;
    memReq    = 1'b0;
    memWe     = 1'b0;
    cpuReady  = 1'b0;
    cpuHit    = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (cpuReq && cpuWe) begin
          stateNext = ST_WRITE;
        end else if (cpuReq) begin
          if (lookupHit) begin
            cpuReady = 1'b1;
            cpuHit   = 1'b1;
          end else begin
            ctrl.allocLine = !tagMatch;
            stateNext      = ST_FILL;
          end
        end
      end
      ST_FILL: begin
        memReq = 1'b1;
        if (memAck) begin
          ctrl.fillSub = 1'b1;
          ctrl.useFill = 1'b1;
          cpuReady     = 1'b1;
          stateNext    = ST_IDLE;
        end
      end
      ST_WRITE: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        if (memAck) begin
          cpuReady       = 1'b1;
          cpuHit         = lookupHit;
          ctrl.writeWord = lookupHit;
          stateNext      = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/subblock_cache.sv
module subblock_cache
  import sbc_pkg::*;
#(
  parameter int ADDR_W        = 10,
  parameter int DATA_W        = 32,
  parameter int WORDS_PER_SUB = 2,
  parameter int SUBS_PER_LINE = 4,
  parameter int LINES         = 8
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            cpuReq,
  input  logic                            cpuWe,
  input  logic [ADDR_W-1:0]               cpuAddr,
  input  logic [DATA_W-1:0]               cpuWdata,
  output logic [DATA_W-1:0]               cpuRdata,
  output logic                            cpuReady,
  output logic                            cpuHit,
  output logic                            memReq,
  output logic                            memWe,
  output logic [ADDR_W-1:0]               memAddr,
  output logic [DATA_W-1:0]               memWdata,
  input  logic                            memAck,
  input  logic [WORDS_PER_SUB*DATA_W-1:0] memRdata
);

  localparam int OFF_W = $clog2(WORDS_PER_SUB);

  dpCtrl_t ctrl;
  logic    tagMatch;
  logic    subValid;

  sbc_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cpuReq   (cpuReq),
    .cpuWe    (cpuWe),
    .tagMatch (tagMatch),
    .subValid (subValid),
    .memAck   (memAck),
    .ctrl     (ctrl),
    .memReq   (memReq),
    .memWe    (memWe),
    .cpuReady (cpuReady),
    .cpuHit   (cpuHit)
  );

  sbc_datapath #(
    .ADDR_W        (ADDR_W),
    .DATA_W        (DATA_W),
    .WORDS_PER_SUB (WORDS_PER_SUB),
    .SUBS_PER_LINE (SUBS_PER_LINE),
    .LINES         (LINES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .cpuAddr  (cpuAddr),
    .cpuWdata (cpuWdata),
    .memRdata (memRdata),
    .tagMatch (tagMatch),
    .subValid (subValid),
    .rdData   (cpuRdata)
  );

  // Refill fetches from the sub-block start; writes use the exact word
  assign memAddr  = memWe ? cpuAddr : {cpuAddr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign memWdata = cpuWdata;

endmodule

// File: rtl/sbc_checker.sv
module sbc_checker #(
  parameter int ADDR_W        = 10,
  parameter int WORDS_PER_SUB = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              cpuReq,
  input logic              cpuWe,
  input logic              cpuReady,
  input logic              cpuHit,
  input logic              memReq,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memAck
);

  localparam int OFF_W = $clog2(WORDS_PER_SUB);

  // R2: a read that completes as a hit never touches memory
  p_read_hit_no_mem_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cpuReq && !cpuWe && cpuReady && cpuHit) |-> !memReq);

  // R5: refill addresses are aligned to a sub-block
  p_fill_aligned_r5: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memWe) |-> (memAddr[OFF_W-1:0] == '0));

  // R5: exactly one request per miss, dropped after the acknowledge
  p_one_request_r5: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memAck) |=> !memReq);

  // R6: requester is stalled while memory has not answered
  p_stall_r6: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |-> !cpuReady);

  // R6: a refill completes in its acknowledge cycle as a miss
  p_fill_complete_r6: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memWe && memAck) |-> (cpuReady && !cpuHit));

  // R7: every completed write went to memory
  p_write_through_r7: assert property (@(posedge clk) disable iff (!rstN)
    (cpuReq && cpuWe && cpuReady) |-> (memReq && memWe && memAck));

endmodule

bind subblock_cache sbc_checker #(
  .ADDR_W        (ADDR_W),
  .WORDS_PER_SUB (WORDS_PER_SUB)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .cpuReq   (cpuReq),
  .cpuWe    (cpuWe),
  .cpuReady (cpuReady),
  .cpuHit   (cpuHit),
  .memReq   (memReq),
  .memWe    (memWe),
  .memAddr  (memAddr),
  .memAck   (memAck)
);

// File: tb/subblock_cache_tb.sv
`timescale 1ns/1ps
module subblock_cache_tb;

  localparam int AW   = 8;
  localparam int DW   = 32;
  localparam int WPS  = 2;
  localparam int SPL  = 4;
  localparam int NL   = 4;
  localparam int MSZ  = 1 << AW;
  localparam int LAT  = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cpuReq = 1'b0, cpuWe = 1'b0;
  logic [AW-1:0] cpuAddr = '0;
  logic [DW-1:0] cpuWdata = '0;
  logic [DW-1:0] cpuRdata;
  logic cpuReady, cpuHit, memReq, memWe, memAck;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memWdata;
  logic [WPS*DW-1:0] memRdata;

  always #2.5 clk = ~clk;

  subblock_cache #(
    .ADDR_W(AW), .DATA_W(DW), .WORDS_PER_SUB(WPS), .SUBS_PER_LINE(SPL), .LINES(NL)
  ) u_dut (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuRdata(cpuRdata), .cpuReady(cpuReady), .cpuHit(cpuHit),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memAck(memAck), .memRdata(memRdata)
  );

  // Memory model
  logic [DW-1:0] mem [MSZ];
  logic busy = 1'b0;
  int   cnt = 0;
  int   reqCount = 0;
  logic [AW-1:0] lastAddr = '0;
  logic lastWe = 1'b0;
  logic [DW-1:0] lastWdata = '0;

  initial begin
    memAck = 1'b0;
    memRdata = '0;
    for (int i = 0; i < MSZ; i++) mem[i] = (i * 32'h0100_0193) ^ 32'hA5A5_0000;
  end

  always @(posedge clk) begin
    if (memAck) begin
      memAck <= 1'b0;
      busy   <= 1'b0;
      if (lastWe) mem[lastAddr] <= lastWdata;
    end else if (busy) begin
      if (cnt == 0) begin
        memAck <= 1'b1;
        for (int w = 0; w < WPS; w++) memRdata[w*DW +: DW] <= mem[int'(lastAddr) + w];
      end else begin
        cnt <= cnt - 1;
      end
    end else if (memReq) begin
      busy      <= 1'b1;
      cnt       <= LAT;
      reqCount  <= reqCount + 1;
      lastAddr  <= memAddr;
      lastWe    <= memWe;
      lastWdata <= memWdata;
    end
  end

  // Scoreboard
  int nCmp = 0, nBad = 0;
  logic [AW-1:0] refTag [NL];
  logic [SPL-1:0] refValid [NL];

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nCmp++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic access(input bit we, input int addr, input logic [DW-1:0] wd,
                        input string rq);
    int sub = (addr / WPS) % SPL;
    int idx = (addr / (WPS * SPL)) % NL;
    int tag = addr / (WPS * SPL * NL);
    bit expHit = refValid[idx][sub] && (int'(refTag[idx]) == tag);
    int startCnt = reqCount;
    int waits = 0;
    bit gotHit, ackSeen;
    logic [DW-1:0] gotData;
    @(negedge clk);
    cpuReq = 1'b1; cpuWe = we; cpuAddr = AW'(addr); cpuWdata = wd;
    #1;
    while (!cpuReady && waits < 200) begin
      @(negedge clk); #1; waits++;
    end
    gotHit = cpuHit; gotData = cpuRdata; ackSeen = memAck;
    check(waits < 200, rq, "request completed", 32'(waits), 0);
    @(posedge clk); #1;
    cpuReq = 1'b0;
    check(gotHit == expHit, rq, $sformatf("hit flag addr %0d", addr), 32'(gotHit), 32'(expHit));
    if (!we) begin
      check(gotData == mem[addr], expHit ? rq : "R6", $sformatf("read data addr %0d", addr),
            gotData, mem[addr]);
      if (expHit) begin
        check(reqCount == startCnt && waits == 0, "R2", "hit without memory",
              32'(reqCount - startCnt), 0);
      end else begin
        check(reqCount == startCnt + 1, "R5", "one refill request", 32'(reqCount - startCnt), 1);
        check(lastAddr == AW'(addr - addr % WPS) && !lastWe, "R5", "refill address",
              32'(lastAddr), 32'(addr - addr % WPS));
        check(ackSeen && waits > 0, "R6", "ready in ack cycle", 32'(ackSeen), 1);
        if (int'(refTag[idx]) != tag) begin
          refTag[idx]   = AW'(tag);
          refValid[idx] = '0;
        end
        refValid[idx][sub] = 1'b1;
      end
    end else begin
      check(reqCount == startCnt + 1 && lastWe && lastAddr == AW'(addr) && lastWdata == wd,
            "R7", "write-through request", 32'(lastAddr), 32'(addr));
      check(mem[addr] == wd, "R7", "memory updated", mem[addr], wd);
    end
  endtask

  // Watchdog
  initial begin
    #(200000 * 5);
    nCmp++; nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    for (int i = 0; i < NL; i++) begin refTag[i] = '0; refValid[i] = '0; end
    repeat (4) @(posedge clk);
    #1;
    check(!memReq && !cpuReady, "R1", "idle after reset", 32'({memReq, cpuReady}), 0);
    rstN = 1'b1;
    // R1, R3, R10: ascending sweep over one tag region
    for (int a = 0; a < WPS * SPL * NL; a++) access(1'b0, a, '0, (a % WPS == 0) ? "R1" : "R10");
    // R2: everything now resident
    for (int a = 0; a < WPS * SPL * NL; a++) access(1'b0, a, '0, "R2");
    // R4: conflict in line 0, then return to the old tag
    access(1'b0, 32, '0, "R4");
    access(1'b0, 2,  '0, "R4");
    access(1'b0, 6,  '0, "R4");
    access(1'b0, 3,  '0, "R3");
    access(1'b0, 0,  '0, "R3");
    // R8: write hit then read
    access(1'b1, 10, 32'hDEAD_0010, "R8");
    access(1'b0, 10, '0, "R8");
    access(1'b0, 11, '0, "R8");
    // R9: write misses do not allocate
    access(1'b1, 200, 32'hBEEF_00C8, "R9");
    access(1'b0, 200, '0, "R9");
    access(1'b1, 4, 32'h0000_1234, "R9");
    access(1'b0, 4, '0, "R9");
    access(1'b1, 72, 32'h0000_0048, "R9");
    access(1'b0, 10, '0, "R9");
    // Pseudo-random mix
    lfsr = 16'hACE1;
    for (int k = 0; k < 600; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      access(lfsr[2:0] < 3'd2, int'(lfsr[15:8]) % 96, {lfsr, ~lfsr}, "R2");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule